// File: doc/BRIEF.md
# Two-Tier Round-Robin Bus Grant Arbiter

This block shares one downstream bus master among three requesters: a bus-target path and two DMA channels. It arbitrates on two tiers. The upper tier alternates between the target path and the DMA group as a whole. The lower tier alternates between DMA channel 0 and DMA channel 1. Under full contention the target path therefore wins every other tenure, and the two DMA channels divide the remaining tenures between them.

A requester raises its request line. The arbiter answers with a registered one-hot grant. The holder keeps that grant until it pulses the transfer-done input. A new decision is made only while the bus is idle (no grant) or in the cycle where done is high. The decision appears on the grant output at the next clock edge. Rotation only matters when requests contend: a requester that asks alone is granted again and again.

Top module: `tiered_bus_arbiter`

## Requirements
- R1: A synchronous active-high reset clears the grant to 3'b000. It sets the upper tier to favour the target path and the lower tier to favour DMA channel 0. The first fully contended decision after reset therefore grants the target path.
- R2: The grant is one-hot or zero, with bit 0 = target path, bit 1 = DMA channel 0, bit 2 = DMA channel 1. It changes only at the clock edge that follows a decision cycle.
- R3: When all three requesters ask at every decision, the grant order is target, DMA0, target, DMA1, target, DMA0, and so on.
- R4: A requester that asks alone is granted at every decision, with no forced rotation.
- R5: If the target path has been granted alone and a DMA request then appears, the next decision goes to the DMA group.
- R6: When only one DMA channel asks and is granted, the lower tier moves its priority to the other channel. The next decision where both channels contend for the DMA slot therefore goes to the other channel.
- R7: While a grant is held and transfer-done is low, the grant does not change, whatever the requests do.
- R8: Fairness state moves only when a grant is issued. Decision cycles with no requests leave the priority order unchanged.
- R9: A decision cycle with no request active leaves the grant at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_target | input | 1 | Request from the bus-target path |
| req_dma0 | input | 1 | Request from DMA channel 0 |
| req_dma1 | input | 1 | Request from DMA channel 1 |
| xfer_done | input | 1 | Current tenure ends in this cycle |
| grant | output | 3 | Registered one-hot grant: bit0 target, bit1 DMA0, bit2 DMA1 |

## Verification
Two things can happen in the same cycle: the current tenure ending on transfer-done, and the next decision being made from whatever requests are live in that cycle. Among those requests may be the outgoing holder's own request, and a DMA request arriving while the target path streams alone. The bench provokes this overlap by raising done in the same cycle it changes the request mix. It does so in directed sequences and in a long pseudo-random sweep over every combination of the four inputs. It then compares the grant one edge later against a reference model in the bench that keeps its own two priority bits.

// File: rtl/tiered_arb_pkg.sv
package tiered_arb_pkg;
  localparam int NUM_REQ = 3;
  localparam int SIDE_W  = 2;

  typedef enum logic [1:0] {
    SLOT_TARGET = 2'd0,
    SLOT_DMA0   = 2'd1,
    SLOT_DMA1   = 2'd2
  } slot_e;

  // Two-way round-robin pick: favour_hi selects which side wins a tie.
  function automatic logic [SIDE_W-1:0] pick2(input logic [SIDE_W-1:0] req,
                                              input logic favour_hi);
    logic [SIDE_W-1:0] p;
    if (req == 2'b11) p = favour_hi ? 2'b10 : 2'b01;
    else              p = req;
    return p;
  endfunction

  // Combine the two tiers into the three-bit grant vector.
  function automatic logic [NUM_REQ-1:0] merge_grant(input logic [SIDE_W-1:0] upper,
                                                     input logic [SIDE_W-1:0] lower);
    return {upper[1] & lower[1], upper[1] & lower[0], upper[0]};
  endfunction
endpackage

// File: rtl/rr2_cell.sv
module rr2_cell
  import tiered_arb_pkg::*;
#(
  parameter logic RESET_FAVOUR_HI = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SIDE_W-1:0] req,
  input  logic              advance,
  output logic [SIDE_W-1:0] pick,
  output logic              favour_hi
);
  logic issued;

  assign pick   = pick2(req, favour_hi);
  assign issued = advance && (pick != '0);

  always_ff @(posedge clk) begin
    if (rst)         favour_hi <= RESET_FAVOUR_HI;
    else if (issued) favour_hi <= pick[0];
  end

  a_r2_pick_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pick));
  a_r2_pick_requested: assert property (@(posedge clk) disable iff (rst)
    (pick & ~req) == '0);
  a_r4_lone_wins: assert property (@(posedge clk) disable iff (rst)
    ($countones(req) == 1) |-> (pick == req));
  a_r8_favour_holds: assert property (@(posedge clk) disable iff (rst)
    !issued |=> $stable(favour_hi));
  a_r3_favour_moves: assert property (@(posedge clk) disable iff (rst)
    (issued && req == 2'b11) |=> (favour_hi != $past(favour_hi)));
endmodule

// File: rtl/tenure_ctrl.sv
module tenure_ctrl
  import tiered_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               xfer_done,
  input  logic [NUM_REQ-1:0] next_grant,
  output logic               decide,
  output logic [NUM_REQ-1:0] grant_q
);
  logic idle;

  assign idle   = (grant_q == '0);
  assign decide = idle || xfer_done;

  always_ff @(posedge clk) begin
    if (rst)         grant_q <= '0;
    else if (decide) grant_q <= next_grant;
  end

  a_r7_no_preempt: assert property (@(posedge clk) disable iff (rst)
    (!idle && !xfer_done) |=> $stable(grant_q));
  a_r2_grant_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_q));
endmodule

// File: rtl/tiered_bus_arbiter.sv
module tiered_bus_arbiter
  import tiered_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               req_target,
  input  logic               req_dma0,
  input  logic               req_dma1,
  input  logic               xfer_done,
  output logic [NUM_REQ-1:0] grant
);
  logic              decide;
  logic              dma_any;
  logic [SIDE_W-1:0] upper_req, upper_pick, lower_req, lower_pick;
  logic              upper_fav, lower_fav;
  logic [NUM_REQ-1:0] next_grant;

  assign dma_any   = req_dma0 | req_dma1;
  assign upper_req = {dma_any, req_target};
  assign lower_req = {req_dma1, req_dma0};

  rr2_cell #(.RESET_FAVOUR_HI(1'b0)) u_upper (
    .clk(clk), .rst(rst), .req(upper_req), .advance(decide),
    .pick(upper_pick), .favour_hi(upper_fav));

  rr2_cell #(.RESET_FAVOUR_HI(1'b0)) u_lower (
    .clk(clk), .rst(rst), .req(lower_req), .advance(decide && upper_pick[1]),
    .pick(lower_pick), .favour_hi(lower_fav));

  assign next_grant = merge_grant(upper_pick, lower_pick);

  tenure_ctrl u_tenure (
    .clk(clk), .rst(rst), .xfer_done(xfer_done), .next_grant(next_grant),
    .decide(decide), .grant_q(grant));

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (decide && !req_target && !dma_any) |=> (grant == '0));
  a_r5_dma_after_target: assert property (@(posedge clk) disable iff (rst)
    (decide && grant[0] && req_target && dma_any) |=> (grant[0] == 1'b0));
  a_r6_lower_after_dma: assert property (@(posedge clk) disable iff (rst)
    (decide && upper_pick[1] && lower_pick[0]) |=> (lower_fav == 1'b1));
endmodule

// File: tb/tb_tiered_bus_arbiter.sv
module tb_tiered_bus_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] G_T = 3'b001, G_D0 = 3'b010, G_D1 = 3'b100, G_NONE = 3'b000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_target = 1'b0, req_dma0 = 1'b0, req_dma1 = 1'b0, xfer_done = 1'b0;
  logic [2:0] grant;

  int n_checks = 0;
  int n_fail = 0;

  logic [2:0] m_grant;
  logic m_top_dma;
  logic m_low_d1;

  always #(CLK_PERIOD/2) clk = ~clk;

  tiered_bus_arbiter dut (
    .clk(clk), .rst(rst), .req_target(req_target), .req_dma0(req_dma0),
    .req_dma1(req_dma1), .xfer_done(xfer_done), .grant(grant));

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: grant=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_grant = G_NONE; m_top_dma = 1'b0; m_low_d1 = 1'b0;
  endtask

  task automatic model_step(input logic t, input logic d0, input logic d1, input logic dn);
    logic any_d, win_t, win_d1;
    if (m_grant == G_NONE || dn) begin
      any_d = d0 | d1;
      if (!t && !any_d) m_grant = G_NONE;
      else begin
        win_t = t && (!any_d || !m_top_dma);
        if (win_t) begin m_grant = G_T; m_top_dma = 1'b1; end
        else begin
          win_d1 = d1 && (!d0 || m_low_d1);
          m_grant = win_d1 ? G_D1 : G_D0;
          m_low_d1 = !win_d1;
          m_top_dma = 1'b0;
        end
      end
    end
  endtask

  // Drive at negedge, let the design update at posedge, compare at the next negedge.
  task automatic step(input logic t, input logic d0, input logic d1, input logic dn);
    req_target = t; req_dma0 = d0; req_dma1 = d1; xfer_done = dn;
    @(posedge clk);
    model_step(t, d0, d1, dn);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; req_target = 0; req_dma0 = 0; req_dma1 = 0; xfer_done = 0;
    @(posedge clk); @(posedge clk);
    model_reset();
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: grant=%b expected=done", grant);
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    @(negedge clk);
    do_reset();
    check("R1 reset grant", grant, G_NONE);

    // R3: full contention with done every tenure
    step(1,1,1,1); check("R1 first contended", grant, G_T);
    step(1,1,1,1); check("R3 slot2", grant, G_D0);
    step(1,1,1,1); check("R3 slot3", grant, G_T);
    step(1,1,1,1); check("R3 slot4", grant, G_D1);
    step(1,1,1,1); check("R3 slot5", grant, G_T);
    step(1,1,1,1); check("R3 slot6", grant, G_D0);

    // R4 / R5: target alone, then DMA appears
    do_reset();
    step(1,0,0,1); check("R4 lone target 1", grant, G_T);
    step(1,0,0,1); check("R4 lone target 2", grant, G_T);
    step(1,0,0,1); check("R4 lone target 3", grant, G_T);
    step(1,0,1,1); check("R5 dma after stream", grant, G_D1);
    step(0,1,0,1); check("R4 lone dma0 1", grant, G_D0);
    step(0,1,0,1); check("R4 lone dma0 2", grant, G_D0);

    // R6: single DMA channel moves lower priority
    do_reset();
    step(0,1,0,1); check("R6 dma0 alone", grant, G_D0);
    step(0,1,1,1); check("R6 other channel next", grant, G_D1);
    step(0,1,1,1); check("R6 back to dma0", grant, G_D0);

    // R7: no preemption while done low
    step(1,0,0,0); check("R7 hold a", grant, G_D0);
    step(1,1,1,0); check("R7 hold b", grant, G_D0);
    step(0,0,1,0); check("R7 hold c", grant, G_D0);
    step(1,0,0,1); check("R7 release", grant, G_T);

    // R9 / R8: idle decisions leave grant zero and order unchanged
    step(0,0,0,1); check("R9 idle zero", grant, G_NONE);
    do_reset();
    for (int i = 0; i < 8; i++) begin
      step(0,0,0,(i % 2) == 0);
      check("R8 idle no grant", grant, G_NONE);
    end
    step(1,1,1,1); check("R8 order kept target", grant, G_T);
    step(1,1,1,1); check("R8 order kept dma0", grant, G_D0);

    // R2: pseudo-random sweep against the bench model
    do_reset();
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[1], lfsr[2], lfsr[3] | lfsr[4]);
      check("R2 sweep", grant, m_grant);
    end
    finish_run();
  end
endmodule